// File: doc/BRIEF.md
# Fixed-Point Polynomial Evaluator

This block computes a polynomial value p(x) = c0 + c1·x + c2·x² + … + cN·x^N. The order N is chosen per run, up to a limit set by a parameter. Every quantity is a signed 32-bit scaled integer whose low 7 bits are the fraction. A software model or a neighbouring block first loads the coefficients into a small register bank. It then pulses `start` with the evaluation point and the order.

The engine holds one running power of x and one accumulator, and it has a single signed multiplier. For each term it spends two cycles: one to raise the power and one to multiply that power by the matching coefficient and add the result in. After each multiply, the double-width product is shifted right to restore the scale before any addition. Any intermediate result that leaves the signed 32-bit range is clamped to the nearest limit, and a sticky overflow flag is set.

When the last term has been added, the block pulses `done` and keeps the result and the flag steady until the next start.

Top module: `polyfx_eval`

## Requirements
- R1: Values on `x_in`, `coef_wdata` and `result` are two's-complement 32-bit numbers with 7 fractional bits, so 1.0 is encoded as 128 and -1.0 as -128.
- R2: While the block is idle, a cycle with `coef_we` high stores `coef_wdata` as the coefficient of power `coef_addr` (address 0 is the constant term).
- R3: `start` sampled high while idle captures `x_in` and `order`, clears the overflow flag, clears the accumulator and raises `busy` on the next cycle.
- R4: `result` equals the sum over k = 0..order of P_k·c_k >>> 7, where P_0 = 128, P_k = (P_(k-1)·x) >>> 7, and >>> is an arithmetic (floor) right shift of the full 64-bit product. The terms are added in ascending k.
- R5: `done` is a one-cycle pulse that appears 2·order+1 clock edges after the edge that sampled `start`. `busy` is high from the edge after `start` until the edge that raises `done`, and `busy` is low while `done` is high.
- R6: Every scaled product (a power update or a coefficient term) and every partial sum that exceeds 2^31-1 or falls below -2^31 is replaced by 0x7FFFFFFF or 0x80000000 respectively, and `ovf` goes high and stays high until the next accepted start.
- R7: While `busy` is high, `start` and coefficient writes are ignored. The run in progress keeps its x and order, and the bank keeps its old contents.
- R8: Between `done` and the next accepted start, `result` and `ovf` hold their values.
- R9: After reset, `busy`, `done` and `ovf` are low, `result` is 0 and all coefficients are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Power index of the coefficient being written |
| coef_wdata | input | 32 | Coefficient value, 7 fractional bits |
| start | input | 1 | Begin an evaluation |
| x_in | input | 32 | Evaluation point, 7 fractional bits |
| order | input | 3 | Polynomial order for this run |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Accumulated polynomial value |
| ovf | output | 1 | Sticky saturation flag |

## Verification
The assertions rely on `start` and the coefficient port being sampled only at clock edges, and on `order` never exceeding the configured maximum. The bench keeps to both by driving every input on the falling edge and only with orders from 0 to 7. The bench sweeps all eight orders across several coefficient sets and evaluation points: unity, negative, fractional, zero and large values. Some of those sets are chosen so that both the power chain and the partial sums saturate. Separate runs toggle `start` and write the bank while the block is busy, so that the ignore rule can be seen in the result of that run and of the one after it.

// File: rtl/polyfx_eval.sv
module polyfx_eval #(
  parameter int W         = 32,
  parameter int FRAC      = 7,
  parameter int MAX_ORDER = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         coef_we,
  input  logic [$clog2(MAX_ORDER+1)-1:0] coef_addr,
  input  logic [W-1:0] coef_wdata,
  input  logic         start,
  input  logic [W-1:0] x_in,
  input  logic [$clog2(MAX_ORDER+1)-1:0] order,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic         ovf
);
  localparam int IW = $clog2(MAX_ORDER+1);
  localparam logic [IW-1:0] MAXO = IW'(MAX_ORDER);
  localparam logic [W-1:0] ONE  = W'(1) << FRAC;
  localparam logic [W-1:0] VMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] VMIN = {1'b1, {(W-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_MAC, S_POW} state_t;

  state_t         state;
  logic [W-1:0]   coef [MAX_ORDER+1];
  logic [W-1:0]   x_q, pw, acc;
  logic [IW-1:0]  idx, ord_q, ord_in;
  logic [W-1:0]   mop, tsat;
  logic [2*W-1:0] prod, scaled;
  logic           p_ovf, s_ovf;
  logic [W:0]     sum;
  logic [W-1:0]   sum_sat;

  generate
    if ((1 << IW) > MAX_ORDER + 1) begin : g_clamp
      assign ord_in = (order > MAXO) ? MAXO : order;
    end else begin : g_direct
      assign ord_in = order;
    end
  endgenerate

  assign mop    = (state == S_POW) ? x_q : coef[idx];
  assign prod   = $signed(pw) * $signed(mop);
  assign scaled = $signed(prod) >>> FRAC;
  assign p_ovf  = !((&scaled[2*W-1:W-1]) || !(|scaled[2*W-1:W-1]));
  assign tsat   = p_ovf ? (scaled[2*W-1] ? VMIN : VMAX) : scaled[W-1:0];

  assign sum     = {acc[W-1], acc} + {tsat[W-1], tsat};
  assign s_ovf   = sum[W] ^ sum[W-1];
  assign sum_sat = s_ovf ? (sum[W] ? VMIN : VMAX) : sum[W-1:0];

  assign busy   = (state != S_IDLE);
  assign result = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      x_q   <= '0;
      pw    <= '0;
      acc   <= '0;
      idx   <= '0;
      ord_q <= '0;
      ovf   <= 1'b0;
      done  <= 1'b0;
      for (int i = 0; i <= MAX_ORDER; i++) coef[i] <= '0;
    end else begin
      done <= 1'b0;
      if (coef_we && state == S_IDLE && coef_addr <= MAXO)
        coef[coef_addr] <= coef_wdata;
      case (state)
        S_IDLE: if (start) begin
          x_q   <= x_in;
          ord_q <= ord_in;
          pw    <= ONE;
          acc   <= '0;
          idx   <= '0;
          ovf   <= 1'b0;
          state <= S_MAC;
        end
        S_MAC: begin
          acc <= sum_sat;
          ovf <= ovf | p_ovf | s_ovf;
          if (idx == ord_q) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_POW;
          end
        end
        S_POW: begin
          pw    <= tsat;
          ovf   <= ovf | p_ovf;
          idx   <= idx + 1'b1;
          state <= S_MAC;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: an accepted start begins a run with a clear flag
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !ovf));

  // R6: saturation flag is sticky for the rest of a run
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ovf) |=> ovf);

  // R5: completion is a single-cycle pulse seen only when idle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: the captured point cannot change during a run
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(x_q) && $stable(ord_q));

  // R8: outputs hold while idle without a start
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result) && $stable(ovf)));
endmodule

// File: tb/polyfx_eval_tb.sv
`timescale 1ns/1ps
module polyfx_eval_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        coef_we = 1'b0;
  logic [2:0]  coef_addr = '0;
  logic [31:0] coef_wdata = '0;
  logic        start = 1'b0;
  logic [31:0] x_in = '0;
  logic [2:0]  order = '0;
  logic        busy, done, ovf;
  logic [31:0] result;

  int n_chk = 0;
  int n_bad = 0;
  longint cm [8];

  always #2 clk = ~clk;

  polyfx_eval u_dut (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_wdata(coef_wdata), .start(start), .x_in(x_in), .order(order),
    .busy(busy), .done(done), .result(result), .ovf(ovf));

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v, inout bit f);
    if (v > 64'sd2147483647) begin f = 1'b1; return 64'sd2147483647; end
    if (v < -64'sd2147483648) begin f = 1'b1; return -64'sd2147483648; end
    return v;
  endfunction

  task automatic model(input int ord, input longint x, output longint r, output bit f);
    longint p = 128;
    longint a = 0;
    f = 1'b0;
    for (int k = 0; k <= ord; k++) begin
      a = sat(a + sat((p * cm[k]) >>> 7, f), f);
      if (k < ord) p = sat((p * x) >>> 7, f);
    end
    r = a;
  endtask

  task automatic wr(input int a, input longint v);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 3'(a); coef_wdata = 32'(v);
    @(negedge clk);
    coef_we = 1'b0;
    cm[a] = longint'($signed(32'(v)));
  endtask

  task automatic run(input int ord, input longint x, input bit meddle);
    longint er; bit ef; int n;
    model(ord, x, er, ef);
    @(negedge clk);
    start = 1'b1; x_in = 32'(x); order = 3'(ord);
    @(posedge clk); #1;
    start = 1'b0;
    n = 0;
    do begin
      if (meddle && n == 0) begin
        start = 1'b1; x_in = 32'(x + 999); order = 3'(7 - ord);
        coef_we = 1'b1; coef_addr = 3'd0; coef_wdata = 32'h12345;
      end
      @(posedge clk); #1;
      start = 1'b0; coef_we = 1'b0;
      n++;
    end while (!done && n < 100);
    chk("R5 latency", n, 2 * ord + 1);
    chk("R5 busy low at done", busy, 0);
    chk(meddle ? "R7 result" : "R4 result", longint'($signed(result)), er);
    chk("R6 ovf", ovf, ef);
    @(posedge clk); #1;
    chk("R5 done one cycle", done, 0);
    chk("R8 result holds", longint'($signed(result)), er);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint xs [10];
    xs[0] = 128; xs[1] = -128; xs[2] = 64; xs[3] = 0; xs[4] = 320;
    xs[5] = -200; xs[6] = 1000; xs[7] = 3; xs[8] = 12345; xs[9] = 1 << 20;
    for (int i = 0; i < 8; i++) cm[i] = 0;
    #7;
    chk("R9 busy", busy, 0);
    chk("R9 done", done, 0);
    chk("R9 ovf", ovf, 0);
    chk("R9 result", result, 0);
    rst_n = 1'b1;
    run(3, 128, 1'b0);
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 8; k++) begin
        if (s == 0) wr(k, (k + 1) * 37 - 100);
        else if (s == 1) wr(k, (k % 2 == 1) ? -(k * 5000 + 17) : k * 3001 + 128);
        else wr(k, 64'sh7FFF0000 - k * 1000);
      end
      for (int o = 0; o < 8; o++)
        for (int xi = 0; xi < 10; xi++) run(o, xs[xi], 1'b0);
    end
    // R1: 1.0 with c = 2.0, 1.0 gives 3.0 (384)
    wr(0, 256); wr(1, 128);
    run(1, 128, 1'b0);
    chk("R1 encoding", longint'($signed(result)), 384);
    // R2: rewrite a single coefficient then evaluate
    wr(2, -128);
    run(2, 256, 1'b0);
    // R7: start and write during busy are ignored
    for (int o = 0; o < 8; o++) run(o, 192, 1'b1);
    run(2, 256, 1'b0);
    // R3: ovf cleared by a clean run after an overflow
    wr(0, 64'sh7FFFFFFF); wr(1, 64'sh7FFFFFFF);
    run(1, 128, 1'b0);
    chk("R6 ovf set", ovf, 1);
    wr(0, 5); wr(1, 7);
    run(1, 128, 1'b0);
    chk("R3 ovf cleared", ovf, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule